// File: doc/BRIEF.md
# Timer input capture channel

This block is one capture channel for a general-purpose timer. An internal up-counter advances once every `psc_val + 1` clocks and wraps to zero after it reaches `reload_val`. An external signal passes through a synchronizer and an optional glitch filter, then an edge detector with a selectable polarity. A divider then passes one qualifying edge in 1, 2, 4 or 8. On each event that gets through, the current counter value is stored in a capture register and a sticky flag is raised.

To measure periods, the block keeps the two most recent captures. It outputs their difference and corrects for a counter wrap between them. In the alternative slave-reset mode, each capture also restarts the counter and its prescaler, so the capture register itself holds the elapsed time since the previous event. Software-facing access is reduced to plain configuration inputs, a flag-clear strobe and status outputs.

Top module: `tmr_capture_channel`

## Requirements
- R1: While `cnt_en` is high the counter increments once every `psc_val + 1` clocks, and it holds its value while `cnt_en` is low.
- R2: After the counter holds `reload_val`, its next increment sets it to 0.
- R3: While `in_sel` is 0, no input edge changes `cap_val` or sets `cap_flag`. Any non-zero value enables the channel.
- R4: `edge_sel` selects the edges that qualify: 00 rising only, 01 falling only, 10 or 11 both edges.
- R5: With `filt_cfg` = N > 0, a new input level is accepted only after the synchronized input has held it for N consecutive clocks. Shorter pulses produce no edge. N = 0 disables filtering.
- R6: `cap_div` sets the number of qualifying edges per capture: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8. The edge count restarts when `in_sel` is 0.
- R7: When the newer capture is greater than the older one, `period_diff` equals newer minus older.
- R8: When the newer capture is less than or equal to the older one, `period_diff` equals (`reload_val` + 1 − older) + newer.
- R9: With `slave_rst` high, every capture also clears the counter and its prescaler. A periodic input of P clocks with P a multiple of `psc_val + 1` then captures P/(`psc_val` + 1) − 1.
- R10: Every capture sets `cap_flag`. It stays set until `flag_clr` is pulsed, which clears both flags.
- R11: A capture that occurs while `cap_flag` is already set also sets `ovr_flag`.
- R12: `diff_valid` is 0 until two captures have happened since `in_sel` was last 0, and 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| psc_val | input | PSC_W | Counter prescaler; tick every psc_val+1 clocks |
| reload_val | input | CNT_W | Highest counter value before wrap |
| in_sel | input | 2 | Channel input select; 0 disables capture |
| filt_cfg | input | 4 | Filter length in clocks; 0 bypasses |
| cap_div | input | 2 | Capture divider code |
| edge_sel | input | 2 | Edge polarity code |
| slave_rst | input | 1 | Restart counter on each capture |
| flag_clr | input | 1 | Clears capture and overcapture flags |
| sig_in | input | 1 | Asynchronous signal under measurement |
| cnt_val | output | CNT_W | Current counter value |
| cap_val | output | CNT_W | Most recent captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| ovr_flag | output | 1 | Sticky overcapture flag |
| period_diff | output | CNT_W+1 | Wrap-corrected difference of the last two captures |
| diff_valid | output | 1 | Two captures available for the difference |

## Verification
The bench builds the channel with an 8-bit counter and a 4-bit prescaler. This lets a reload of 255 exercise the all-ones wrap span, whose width needs the extra difference bit. A reload of 15 makes wraps between captures frequent, and a period equal to the span puts two captures on the same counter value. The filter is built in, and the bench runs it at a length of 4 with 3-clock glitches to probe the acceptance boundary.

// File: rtl/tmr_cap_pkg.sv
package tmr_cap_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE  = 2'b00,
      EDGE_FALL  = 2'b01,
      EDGE_BOTH  = 2'b10,
      EDGE_BOTHX = 2'b11
   } edge_sel_e;

   // Terminal value of the edge counter for a divider code
   function automatic logic [2:0] div_last(input logic [1:0] code);
      case (code)
         2'b00:   div_last = 3'd0;
         2'b01:   div_last = 3'd1;
         2'b10:   div_last = 3'd3;
         default: div_last = 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/tmr_cap_counter.sv
module tmr_cap_counter #(
   parameter int CNT_W = 16,
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic [PSC_W-1:0] psc_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             srst,
   output logic [CNT_W-1:0] cnt_q
);

   logic [PSC_W-1:0] presc_q;
   logic             tick;

   assign tick = cnt_en && (presc_q >= psc_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc_q <= '0;
         cnt_q   <= '0;
      end else if (srst) begin
         presc_q <= '0;
         cnt_q   <= '0;
      end else if (cnt_en) begin
         if (tick) begin
            presc_q <= '0;
            if (cnt_q >= reload_val) cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end else begin
            presc_q <= presc_q + 1'b1;
         end
      end
   end

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !srst && cnt_q >= reload_val) |=> (cnt_q == '0)); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !srst && cnt_q < reload_val) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !srst) |=> $stable(cnt_q)); // R1

endmodule

// File: rtl/tmr_cap_input.sv
module tmr_cap_input #(
   parameter int SYNC_STAGES = 2,
   parameter bit FILT_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sig_in,
   input  logic [3:0] filt_cfg,
   input  logic [1:0] edge_sel,
   output logic       edge_evt
);
   import tmr_cap_pkg::*;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;
   logic                   lvl_q;
   logic                   lvl_d_q;
   logic                   rise;
   logic                   fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
   end
   assign sync_out = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_EN) begin : g_filter
         logic [3:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= 1'b0;
            end else if (filt_cfg == 4'd0) begin
               run_q <= '0;
               lvl_q <= sync_out;
            end else if (sync_out != lvl_q) begin
               if (run_q == filt_cfg - 4'd1) begin
                  run_q <= '0;
                  lvl_q <= sync_out;
               end else begin
                  run_q <= run_q + 4'd1;
               end
            end else begin
               run_q <= '0;
            end
         end
         AST_FILT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_cfg != 4'd0 && lvl_q != $past(lvl_q)) |-> ($past(run_q) == filt_cfg - 4'd1)); // R5
      end else begin : g_nofilter
         logic unused_filt;
         assign unused_filt = ^filt_cfg;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= sync_out;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d_q <= 1'b0;
      else        lvl_d_q <= lvl_q;
   end

   assign rise = lvl_q & ~lvl_d_q;
   assign fall = ~lvl_q & lvl_d_q;

   always_comb begin
      case (edge_sel_e'(edge_sel))
         EDGE_RISE: edge_evt = rise;
         EDGE_FALL: edge_evt = fall;
         default:   edge_evt = rise | fall;
      endcase
   end

   AST_LVL_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_out))); // R5
   AST_EDGE_POL: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_evt && edge_sel == 2'b00) |-> lvl_q); // R4

endmodule

// File: rtl/tmr_cap_latch.sv
module tmr_cap_latch #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       in_sel,
   input  logic [1:0]       cap_div,
   input  logic             edge_evt,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             flag_clr,
   output logic             cap_evt,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag,
   output logic             ovr_flag,
   output logic [CNT_W:0]   period_diff,
   output logic             diff_valid
);
   import tmr_cap_pkg::*;

   localparam int DW = CNT_W + 1;

   logic             chan_on;
   logic             qual;
   logic [2:0]       ev_cnt_q;
   logic [1:0]       ncap_q;
   logic [CNT_W-1:0] old_q;
   logic [DW-1:0]    span;

   assign chan_on = (in_sel != 2'b00);
   assign qual    = edge_evt && chan_on;
   assign cap_evt = qual && (ev_cnt_q == div_last(cap_div));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_cnt_q <= '0;
         ncap_q   <= '0;
      end else if (!chan_on) begin
         ev_cnt_q <= '0;
         ncap_q   <= '0;
      end else if (qual) begin
         ev_cnt_q <= cap_evt ? 3'd0 : ev_cnt_q + 3'd1;
         if (cap_evt && ncap_q != 2'd2) ncap_q <= ncap_q + 2'd1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val <= '0;
         old_q   <= '0;
      end else if (cap_evt) begin
         old_q   <= cap_val;
         cap_val <= cnt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_flag <= 1'b0;
         ovr_flag <= 1'b0;
      end else begin
         if (cap_evt)       cap_flag <= 1'b1;
         else if (flag_clr) cap_flag <= 1'b0;
         if (flag_clr)                 ovr_flag <= 1'b0;
         else if (cap_evt && cap_flag) ovr_flag <= 1'b1;
      end
   end

   assign span       = {1'b0, reload_val} + 1'b1;
   assign diff_valid = (ncap_q == 2'd2);

   always_comb begin
      if (cap_val > old_q) period_diff = {1'b0, cap_val} - {1'b0, old_q};
      else                 period_diff = span - {1'b0, old_q} + {1'b0, cap_val};
   end

   AST_NO_CAP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sel == 2'b00) |=> $stable(cap_val)); // R3
   AST_FLAG_ON_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> cap_flag); // R10
   AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $past(cap_flag)); // R11
   AST_DIV_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_div == 2'b00 && qual) |-> cap_evt); // R6
   AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sel == 2'b00) |=> !diff_valid); // R12

endmodule

// File: rtl/tmr_capture_channel.sv
module tmr_capture_channel #(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit FILT_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic [PSC_W-1:0] psc_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [1:0]       in_sel,
   input  logic [3:0]       filt_cfg,
   input  logic [1:0]       cap_div,
   input  logic [1:0]       edge_sel,
   input  logic             slave_rst,
   input  logic             flag_clr,
   input  logic             sig_in,
   output logic [CNT_W-1:0] cnt_val,
   output logic [CNT_W-1:0] cap_val,
   output logic             cap_flag,
   output logic             ovr_flag,
   output logic [CNT_W:0]   period_diff,
   output logic             diff_valid
);

   generate
      if (CNT_W < 2)       begin : g_chk_cnt  $error("CNT_W must be at least 2");       end
      if (PSC_W < 1)       begin : g_chk_psc  $error("PSC_W must be at least 1");       end
      if (SYNC_STAGES < 2) begin : g_chk_sync $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   logic edge_evt;
   logic cap_evt;
   logic srst;

   assign srst = slave_rst && cap_evt;

   tmr_cap_counter #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_en     (cnt_en),
      .psc_val    (psc_val),
      .reload_val (reload_val),
      .srst       (srst),
      .cnt_q      (cnt_val)
   );

   tmr_cap_input #(.SYNC_STAGES(SYNC_STAGES), .FILT_EN(FILT_EN)) i_input (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_in   (sig_in),
      .filt_cfg (filt_cfg),
      .edge_sel (edge_sel),
      .edge_evt (edge_evt)
   );

   tmr_cap_latch #(.CNT_W(CNT_W)) i_latch (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_sel      (in_sel),
      .cap_div     (cap_div),
      .edge_evt    (edge_evt),
      .cnt         (cnt_val),
      .reload_val  (reload_val),
      .flag_clr    (flag_clr),
      .cap_evt     (cap_evt),
      .cap_val     (cap_val),
      .cap_flag    (cap_flag),
      .ovr_flag    (ovr_flag),
      .period_diff (period_diff),
      .diff_valid  (diff_valid)
   );

   AST_SLAVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_rst && cap_evt) |=> (cnt_val == '0)); // R9

endmodule

// File: tb/test_tmr_capture_channel.sv
module test_tmr_capture_channel;

   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 8;
   localparam int PSC_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cnt_en = 1'b0;
   logic [PSC_W-1:0] psc_val = '0;
   logic [CNT_W-1:0] reload_val = '0;
   logic [1:0]       in_sel = '0;
   logic [3:0]       filt_cfg = '0;
   logic [1:0]       cap_div = '0;
   logic [1:0]       edge_sel = '0;
   logic             slave_rst = 1'b0;
   logic             flag_clr;
   logic             sig_in = 1'b0;
   logic [CNT_W-1:0] cnt_val;
   logic [CNT_W-1:0] cap_val;
   logic             cap_flag;
   logic             ovr_flag;
   logic [CNT_W:0]   period_diff;
   logic             diff_valid;

   logic mon_clr = 1'b0;
   logic tst_clr = 1'b0;
   assign flag_clr = mon_clr | tst_clr;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    cap_seen = 0;
   int    exp_q[$];
   int    cmp_mode = 0;   // 0 off, 1 period_diff, 2 cap_val
   string cur_req = "R7";
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_capture_channel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_tmr_capture_channel (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .psc_val(psc_val),
      .reload_val(reload_val), .in_sel(in_sel), .filt_cfg(filt_cfg),
      .cap_div(cap_div), .edge_sel(edge_sel), .slave_rst(slave_rst),
      .flag_clr(flag_clr), .sig_in(sig_in), .cnt_val(cnt_val),
      .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag),
      .period_diff(period_diff), .diff_valid(diff_valid)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops one expectation per capture and acknowledges the flag
   initial begin
      forever begin
         @(negedge clk);
         mon_clr = 1'b0;
         if (rst_n && cmp_mode != 0 && cap_flag) begin
            cap_seen++;
            mon_clr = 1'b1;
            if (exp_q.size() == 0) begin
               chk({cur_req, " unexpected capture"}, 1, 0);
            end else begin
               int e;
               e = exp_q.pop_front();
               if (e < 0) begin
                  chk("R12 first capture no diff", int'(diff_valid), 0);
               end else if (cmp_mode == 1) begin
                  chk("R12 diff valid", int'(diff_valid), 1);
                  chk(cur_req, int'(period_diff), e);
               end else begin
                  chk(cur_req, int'(cap_val), e);
               end
            end
         end
      end
   end

   task automatic arm();
      @(negedge clk); in_sel = 2'b00;
      repeat (2) @(negedge clk);
      in_sel = 2'b01;
      @(negedge clk);
   endtask

   task automatic wave(input int hi, input int lo, input int n);
      for (int i = 0; i < n; i++) begin
         sig_in = 1'b1;
         repeat (hi) @(negedge clk);
         sig_in = 1'b0;
         repeat (lo) @(negedge clk);
      end
   endtask

   task automatic drain(input string req);
      repeat (40) @(negedge clk);
      chk({req, " all expected captures seen"}, exp_q.size(), 0);
   endtask

   // Driver: pushes expectations, then produces the waveform
   task automatic burst(input string req, input int hi, input int lo, input int n,
                        input int nexp, input int val0, input int val1);
      cur_req = req;
      arm();
      for (int k = 0; k < nexp; k++)
         exp_q.push_back(k == 0 ? -1 : ((k % 2 == 1) ? val0 : val1));
      wave(hi, lo, n);
      drain(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      psc_val = 4'd2;
      reload_val = 8'd9;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset cnt", int'(cnt_val), 0);
      chk("R10 reset flag", int'(cap_flag), 0);
      chk("R11 reset ovr", int'(ovr_flag), 0);
      chk("R12 reset valid", int'(diff_valid), 0);
      chk("R3 reset cap", int'(cap_val), 0);

      // R1/R2: prescaled counting and wrap
      cnt_en = 1'b1;
      repeat (27) @(negedge clk);
      chk("R1 count after 27 clocks", int'(cnt_val), 9);
      repeat (3) @(negedge clk);
      chk("R2 wrap to zero", int'(cnt_val), 0);
      repeat (3) @(negedge clk);
      chk("R1 one tick", int'(cnt_val), 1);
      cnt_en = 1'b0;
      repeat (10) @(negedge clk);
      chk("R1 hold when disabled", int'(cnt_val), 1);

      cnt_en = 1'b1;
      psc_val = 4'd0;
      reload_val = 8'd255;
      cmp_mode = 1;

      edge_sel = 2'b00;
      burst("R7 rising period", 7, 13, 4, 4, 20, 20);
      edge_sel = 2'b01;
      burst("R4 falling period", 7, 13, 3, 3, 20, 20);
      edge_sel = 2'b10;
      burst("R4 both edges", 7, 13, 2, 4, 7, 13);
      edge_sel = 2'b00;

      reload_val = 8'd15;
      burst("R8 wrap diff", 6, 6, 5, 5, 12, 12);
      burst("R8 equal captures", 8, 8, 4, 4, 16, 16);
      reload_val = 8'd255;

      psc_val = 4'd3;
      burst("R1 prescaled diff", 10, 10, 3, 3, 5, 5);
      psc_val = 4'd0;

      cap_div = 2'b01;
      burst("R6 every 2nd edge", 5, 5, 4, 2, 20, 20);
      cap_div = 2'b11;
      burst("R6 every 8th edge", 5, 5, 16, 2, 80, 80);
      cap_div = 2'b00;

      // R5: 3-clock glitches rejected with filter length 4
      filt_cfg = 4'd4;
      cur_req = "R5 glitch";
      arm();
      begin
         int seen0;
         seen0 = cap_seen;
         wave(3, 10, 3);
         repeat (20) @(negedge clk);
         chk("R5 glitches ignored", cap_seen - seen0, 0);
      end
      burst("R5 filtered period", 10, 10, 3, 3, 20, 20);
      filt_cfg = 4'd0;

      // R3: disabled channel
      begin
         int seen0;
         int cv0;
         seen0 = cap_seen;
         cv0 = int'(cap_val);
         in_sel = 2'b00;
         wave(10, 10, 3);
         repeat (20) @(negedge clk);
         chk("R3 no capture when disabled", cap_seen - seen0, 0);
         chk("R3 cap_val unchanged", int'(cap_val), cv0);
         chk("R3 flag clear", int'(cap_flag), 0);
      end

      // R9: slave reset mode
      cmp_mode = 2;
      slave_rst = 1'b1;
      psc_val = 4'd1;
      burst("R9 slave reset capture", 10, 10, 4, 4, 9, 9);
      slave_rst = 1'b0;
      psc_val = 4'd0;

      // R10/R11: flags without acknowledgement
      cmp_mode = 0;
      arm();
      wave(10, 10, 1);
      repeat (20) @(negedge clk);
      chk("R10 flag set", int'(cap_flag), 1);
      chk("R11 no overcapture yet", int'(ovr_flag), 0);
      wave(10, 10, 1);
      repeat (20) @(negedge clk);
      chk("R11 overcapture set", int'(ovr_flag), 1);
      chk("R10 flag still set", int'(cap_flag), 1);
      tst_clr = 1'b1;
      @(negedge clk);
      tst_clr = 1'b0;
      @(negedge clk);
      chk("R10 flag cleared", int'(cap_flag), 0);
      chk("R11 overcapture cleared", int'(ovr_flag), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule